// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This block keeps the status byte of a serial memory slave and rules on every write that the command decoder asks for. The decoder hands it single-cycle strobes: set the write-enable latch, clear the latch, write the status byte, and start an array write at a given address. The block also sees the level of the write-protect pin. It answers with a one-cycle grant for each accepted write and keeps the status byte for readback at any time, including while a write is in progress.

A small internal timer models the write cycle. Any granted write starts the timer, and the in-progress flag stays up for a fixed number of clock cycles. While the flag is up, every new write is refused. Two things gate writes. Two block-protect bits fence off a top slice of the array, which applies to array writes. A protect-enable bit together with a low pin freezes the retained status bits, which applies to status writes. Retained bits take parameter values at reset in place of real retained storage.

Top module: `stat_guard`

## Requirements
- R1: `status_byte` has this layout: bit 7 is protect-enable, bits 6:4 always read 0, bits 3:2 are the block-protect field, bit 1 is the write-enable latch (WEL) and bit 0 is write-in-progress (WIP). Data written to bits 6:4 and 1:0 by a status write has no effect on those bits.
- R2: While `rst` is high and in the cycle after it, WEL=0, WIP=0, both grants are 0, and protect-enable and block-protect equal `RST_PEN` and `RST_SPAN` (both 0 by default).
- R3: `set_wel` sets WEL and `clr_wel` clears it, in the cycle after the strobe. This happens whatever the protection state and even while WIP=1. If both strobes arrive in the same cycle, the clear wins.
- R4: A granted write of either kind shows WEL=0 in the cycle its grant is visible. A refused write leaves WEL unchanged.
- R5: A status write with WEL=0 is refused. There is no grant and the status byte is unchanged.
- R6: A status write is granted when WEL=1, WIP=0, and either `wp_level` is 1 or protect-enable is 0. When granted, it loads `stat_wr_data[7]` into protect-enable and `stat_wr_data[3:2]` into block-protect. When `wp_level` is 0 and protect-enable is 1, the status write is refused.
- R7: An array write is granted only when WEL=1, WIP=0 and the address lies outside the protected range. `wp_level` has no effect on array writes.
- R8: The block-protect field selects the protected range of the 2^ADDR_W byte array. 00 protects nothing, 01 protects the top quarter (addr >= 0xC00 at the default width), 10 protects the top half (addr >= 0x800), and 11 protects the whole array.
- R9: After a grant, WIP reads 1 for exactly `WR_CYCLES` cycles, starting in the cycle the grant is visible. Every write request made while WIP=1 is refused.
- R10: Grants are registered single-cycle pulses that appear in the cycle after the request. If a status write and an array write are requested together, only the status write can be granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_level | input | 1 | Write-protect pin level (0 = protect asserted) |
| set_wel | input | 1 | Strobe: set the write-enable latch |
| clr_wel | input | 1 | Strobe: clear the write-enable latch |
| stat_wr_req | input | 1 | Strobe: status write request |
| stat_wr_data | input | 8 | Byte offered by a status write |
| mem_wr_req | input | 1 | Strobe: array write start request |
| mem_wr_addr | input | ADDR_W | Target byte address of the array write |
| status_byte | output | 8 | Status byte for readback |
| stat_wr_grant | output | 1 | Status write accepted (one-cycle pulse) |
| mem_wr_grant | output | 1 | Array write accepted (one-cycle pulse) |

## Verification
The bench walks addresses on both sides of each protected boundary (0xBFF/0xC00 and 0x7FF/0x800). A decoder that is off by one, or that uses the wrong bit pair, would grant into a fenced slice or refuse a legal address. It drives the pin low with protect-enable both set and clear, to show that the pin blocks only status writes and never array writes. It also issues status writes with the ignored bits set; a design that loaded all eight bits would show junk in bits 6:4 or a forced latch. Writes and latch strobes arrive while the timer runs, with the busy length counted exactly, and the set and clear strobes arrive together. A wrong priority would leave the latch set, grant into a running cycle, or clip the in-progress window.

// File: rtl/stat_guard_pkg.sv
package stat_guard_pkg;

  // Bit positions inside the status byte
  localparam int unsigned SB_PEN  = 7;
  localparam int unsigned SB_BPHI = 3;
  localparam int unsigned SB_BPLO = 2;
  localparam int unsigned SB_WEL  = 1;
  localparam int unsigned SB_WIP  = 0;

  // Protected-range selector carried in the block-protect field
  typedef enum logic [1:0] {
    SPAN_NONE    = 2'b00,
    SPAN_QUARTER = 2'b01,
    SPAN_HALF    = 2'b10,
    SPAN_ALL     = 2'b11
  } prot_span_t;

endpackage

// File: rtl/stat_guard_range.sv
module stat_guard_range
  import stat_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  prot_span_t        span,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam logic [ADDR_W-1:0] QUARTER_BASE = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] HALF_BASE    = {1'b1, {(ADDR_W-1){1'b0}}};

  always_comb begin
    unique case (span)
      SPAN_NONE:    hit = 1'b0;
      SPAN_QUARTER: hit = (addr >= QUARTER_BASE);
      SPAN_HALF:    hit = (addr >= HALF_BASE);
      default:      hit = 1'b1;
    endcase
  end

endmodule

// File: rtl/stat_guard_timer.sv
module stat_guard_timer #(
  parameter int unsigned CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (start) begin
      remain_q <= LOAD;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign busy = (remain_q != '0);

endmodule

// File: rtl/stat_guard.sv
module stat_guard
  import stat_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned WR_CYCLES = 20,
  parameter logic        RST_PEN   = 1'b0,
  parameter logic [1:0]  RST_SPAN  = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_level,
  input  logic              set_wel,
  input  logic              clr_wel,
  input  logic              stat_wr_req,
  input  logic [7:0]        stat_wr_data,
  input  logic              mem_wr_req,
  input  logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        status_byte,
  output logic              stat_wr_grant,
  output logic              mem_wr_grant
);

  logic       pen_q;
  prot_span_t span_q;
  logic       wel_q;
  logic       sgnt_q;
  logic       mgnt_q;
  logic       busy;
  logic       range_hit;
  logic       hw_lock;
  logic       stat_ok;
  logic       mem_ok;
  logic       unused_data_bits;

  stat_guard_range #(.ADDR_W(ADDR_W)) u_range (
    .span (span_q),
    .addr (mem_wr_addr),
    .hit  (range_hit)
  );

  stat_guard_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (stat_ok | mem_ok),
    .busy  (busy)
  );

  // Pin low with protect-enable set freezes the retained status bits
  assign hw_lock = pen_q & ~wp_level;
  assign stat_ok = stat_wr_req & wel_q & ~busy & ~hw_lock;
  assign mem_ok  = mem_wr_req & wel_q & ~busy & ~range_hit & ~stat_ok;

  // Only bits 7 and 3:2 of a status write are stored
  assign unused_data_bits = ^{stat_wr_data[6:4], stat_wr_data[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pen_q  <= RST_PEN;
      span_q <= prot_span_t'(RST_SPAN);
      wel_q  <= 1'b0;
      sgnt_q <= 1'b0;
      mgnt_q <= 1'b0;
    end else begin
      sgnt_q <= stat_ok;
      mgnt_q <= mem_ok;
      if (stat_ok) begin
        pen_q  <= stat_wr_data[SB_PEN];
        span_q <= prot_span_t'(stat_wr_data[SB_BPHI:SB_BPLO]);
      end
      if (stat_ok || mem_ok) begin
        wel_q <= 1'b0;
      end else if (clr_wel) begin
        wel_q <= 1'b0;
      end else if (set_wel) begin
        wel_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status_byte                  = '0;
    status_byte[SB_PEN]          = pen_q;
    status_byte[SB_BPHI:SB_BPLO] = span_q;
    status_byte[SB_WEL]          = wel_q;
    status_byte[SB_WIP]          = busy;
  end

  assign stat_wr_grant = sgnt_q;
  assign mem_wr_grant  = mgnt_q;

endmodule

// File: rtl/stat_guard_chk.sv
module stat_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       wp_level,
  input logic       set_wel,
  input logic       clr_wel,
  input logic       stat_wr_req,
  input logic       mem_wr_req,
  input logic [7:0] status_byte,
  input logic       stat_wr_grant,
  input logic       mem_wr_grant
);

  AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(stat_wr_grant && mem_wr_grant)); // R10

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_byte[6:4] == 3'b000); // R1

  AST_WEL_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    (stat_wr_grant || mem_wr_grant) |-> !status_byte[1]); // R4

  AST_WIP_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    (stat_wr_grant || mem_wr_grant) |-> status_byte[0]); // R9

  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (status_byte[0] && (stat_wr_req || mem_wr_req)) |=> !(stat_wr_grant || mem_wr_grant)); // R9

  AST_NO_WEL_STAT: assert property (@(posedge clk) disable iff (rst)
    (stat_wr_req && !status_byte[1]) |=> (!stat_wr_grant && $stable(status_byte[7:2]))); // R5

  AST_NO_WEL_MEM: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && !status_byte[1]) |=> !mem_wr_grant); // R7

  AST_HW_LOCK: assert property (@(posedge clk) disable iff (rst)
    (stat_wr_req && status_byte[7] && !wp_level) |=> (!stat_wr_grant && $stable(status_byte[7:2]))); // R6

  AST_CLR_WEL: assert property (@(posedge clk) disable iff (rst)
    clr_wel |=> !status_byte[1]); // R3

  AST_SET_WEL: assert property (@(posedge clk) disable iff (rst)
    (set_wel && !clr_wel && !stat_wr_req && !mem_wr_req) |=> status_byte[1]); // R3

endmodule

bind stat_guard stat_guard_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .wp_level      (wp_level),
  .set_wel       (set_wel),
  .clr_wel       (clr_wel),
  .stat_wr_req   (stat_wr_req),
  .mem_wr_req    (mem_wr_req),
  .status_byte   (status_byte),
  .stat_wr_grant (stat_wr_grant),
  .mem_wr_grant  (mem_wr_grant)
);

// File: tb/test_stat_guard.sv
`timescale 1ns/1ps
module test_stat_guard;

  localparam int unsigned AW  = 12;
  localparam int unsigned WRC = 20;
  localparam int unsigned NV  = 25;

  typedef struct packed {
    logic        set;
    logic        clr;
    logic        swr;
    logic [7:0]  sdata;
    logic        mwr;
    logic [11:0] addr;
    logic        wp;
    logic [7:0]  est;
    logic        esg;
    logic        emg;
    logic [3:0]  rq;
  } vec_t;

  // {set, clr, swr, sdata, mwr, addr, wp, expected status, exp stat grant, exp mem grant, req}
  localparam logic [38:0] TBL [NV] = '{
    {3'b001, 8'h8C, 1'b0, 12'h000, 1'b1, 8'h00, 2'b00, 4'd5},  // R5 no latch
    {3'b100, 8'h00, 1'b0, 12'h000, 1'b1, 8'h02, 2'b00, 4'd3},  // R3 set
    {3'b000, 8'h00, 1'b1, 12'h000, 1'b1, 8'h01, 2'b01, 4'd4},  // R4 latch cleared by grant
    {3'b100, 8'h00, 1'b0, 12'h000, 1'b1, 8'h02, 2'b00, 4'd3},  // R3
    {3'b001, 8'hF7, 1'b0, 12'h000, 1'b1, 8'h85, 2'b10, 4'd1},  // R1 ignored bits
    {3'b100, 8'h00, 1'b0, 12'h000, 1'b1, 8'h86, 2'b00, 4'd3},  // R3
    {3'b000, 8'h00, 1'b1, 12'hC00, 1'b1, 8'h86, 2'b00, 4'd8},  // R8 quarter edge in
    {3'b000, 8'h00, 1'b1, 12'hBFF, 1'b1, 8'h85, 2'b01, 4'd8},  // R8 quarter edge out
    {3'b100, 8'h00, 1'b0, 12'h000, 1'b1, 8'h86, 2'b00, 4'd3},  // R3
    {3'b001, 8'h00, 1'b0, 12'h000, 1'b0, 8'h86, 2'b00, 4'd6},  // R6 pin lock
    {3'b000, 8'h00, 1'b1, 12'hFFF, 1'b0, 8'h86, 2'b00, 4'd8},  // R8
    {3'b000, 8'h00, 1'b1, 12'h100, 1'b0, 8'h85, 2'b01, 4'd7},  // R7 pin ignored
    {3'b100, 8'h00, 1'b0, 12'h000, 1'b1, 8'h86, 2'b00, 4'd3},  // R3
    {3'b001, 8'h08, 1'b0, 12'h000, 1'b1, 8'h09, 2'b10, 4'd6},  // R6 pin high
    {3'b100, 8'h00, 1'b0, 12'h000, 1'b1, 8'h0A, 2'b00, 4'd3},  // R3
    {3'b000, 8'h00, 1'b1, 12'h800, 1'b1, 8'h0A, 2'b00, 4'd8},  // R8 half edge in
    {3'b000, 8'h00, 1'b1, 12'h7FF, 1'b1, 8'h09, 2'b01, 4'd4},  // R4 half edge out
    {3'b110, 8'h00, 1'b0, 12'h000, 1'b1, 8'h08, 2'b00, 4'd3},  // R3 clear wins
    {3'b100, 8'h00, 1'b0, 12'h000, 1'b1, 8'h0A, 2'b00, 4'd3},  // R3
    {3'b010, 8'h00, 1'b0, 12'h000, 1'b1, 8'h08, 2'b00, 4'd3},  // R3 clear
    {3'b100, 8'h00, 1'b0, 12'h000, 1'b1, 8'h0A, 2'b00, 4'd3},  // R3
    {3'b001, 8'h0C, 1'b0, 12'h000, 1'b0, 8'h0D, 2'b10, 4'd6},  // R6 pin low, enable off
    {3'b100, 8'h00, 1'b0, 12'h000, 1'b0, 8'h0E, 2'b00, 4'd3},  // R3
    {3'b000, 8'h00, 1'b1, 12'h000, 1'b0, 8'h0E, 2'b00, 4'd8},  // R8 whole array
    {3'b010, 8'h00, 1'b0, 12'h000, 1'b0, 8'h0C, 2'b00, 4'd3}   // R3
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wp_level = 1'b1;
  logic          set_wel = 1'b0;
  logic          clr_wel = 1'b0;
  logic          stat_wr_req = 1'b0;
  logic [7:0]    stat_wr_data = '0;
  logic          mem_wr_req = 1'b0;
  logic [AW-1:0] mem_wr_addr = '0;
  logic [7:0]    status_byte;
  logic          stat_wr_grant;
  logic          mem_wr_grant;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  stat_guard #(.ADDR_W(AW), .WR_CYCLES(WRC)) i_stat_guard (
    .clk           (clk),
    .rst           (rst),
    .wp_level      (wp_level),
    .set_wel       (set_wel),
    .clr_wel       (clr_wel),
    .stat_wr_req   (stat_wr_req),
    .stat_wr_data  (stat_wr_data),
    .mem_wr_req    (mem_wr_req),
    .mem_wr_addr   (mem_wr_addr),
    .status_byte   (status_byte),
    .stat_wr_grant (stat_wr_grant),
    .mem_wr_grant  (mem_wr_grant)
  );

  task automatic chk(input int rq, input logic [9:0] exp);
    logic [9:0] act;
    act = {stat_wr_grant, mem_wr_grant, status_byte};
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL R%0d: got grants/status %h expected %h", rq, act, exp);
    end
  endtask

  // Called at a falling edge: drive for exactly one rising edge, return at the next falling edge
  task automatic apply(input logic s, input logic c, input logic sw, input logic [7:0] d,
                       input logic mw, input logic [AW-1:0] a, input logic wp);
    set_wel = s; clr_wel = c; stat_wr_req = sw; stat_wr_data = d;
    mem_wr_req = mw; mem_wr_addr = a; wp_level = wp;
    @(negedge clk);
    set_wel = 1'b0; clr_wel = 1'b0; stat_wr_req = 1'b0; mem_wr_req = 1'b0;
  endtask

  task automatic drain();
    repeat (WRC + 2) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    int busy_cnt;
    repeat (3) @(negedge clk);
    chk(2, 10'h000);                      // R2 during reset
    rst = 1'b0;
    @(negedge clk);
    chk(2, 10'h000);                      // R2 after reset

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(TBL[i]);
      apply(v.set, v.clr, v.swr, v.sdata, v.mwr, v.addr, v.wp);
      chk(int'(v.rq), {v.esg, v.emg, v.est});
      if (v.esg || v.emg) drain();
    end

    // Busy window: status now 0x0C; open protection first
    apply(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, '0, 1'b1);
    chk(3, 10'h00E);                                      // R3
    apply(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, '0, 1'b1);
    chk(9, 10'h201);                                      // R9 grant, WIP up
    busy_cnt = 1;
    apply(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, '0, 1'b1);
    chk(3, 10'h003);                                      // R3 set while busy
    busy_cnt++;
    apply(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, '0, 1'b1);
    chk(9, 10'h003);                                      // R9 array write refused while busy
    busy_cnt++;
    apply(1'b0, 1'b0, 1'b1, 8'h8C, 1'b0, '0, 1'b1);
    chk(9, 10'h003);                                      // R9 status write refused while busy
    busy_cnt++;
    while (status_byte[0] && busy_cnt < 4 * WRC) begin
      @(negedge clk);
      if (status_byte[0]) busy_cnt++;
    end
    n_checks++;
    if (busy_cnt != WRC) begin
      n_errs++;
      $display("FAIL R9: got busy cycles %0d expected %0d", busy_cnt, WRC);
    end
    chk(9, 10'h002);                                      // R9 latch kept after refusals

    // Simultaneous requests: status write wins
    apply(1'b0, 1'b0, 1'b1, 8'h00, 1'b1, '0, 1'b1);
    chk(10, 10'h201);                                     // R10
    drain();
    chk(10, 10'h000);                                     // R10 pulse ended

    // Reset in mid-run
    apply(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, '0, 1'b1);
    apply(1'b0, 1'b0, 1'b1, 8'h84, 1'b0, '0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(2, 10'h000);                                      // R2 mid-run reset

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule